// File: doc/BRIEF.md
# Addressable Multidrop Test-Port Switch

This block sits between a test access port shared by many boards on a backplane (the primary side) and the single test access port of its own board (the secondary side). It watches the primary clock, mode, data and reset lines and keeps a copy of the standard 16-state test controller. While that controller rests in one of its four stable states, a short serial address frame can arrive on primary TDI. When the frame carries the address set on the static `board_addr` pins, the block echoes the address back on primary TDO and links the two ports.

While linked, primary clock, mode, data and reset reach the secondary port through gates only, and secondary TDO returns to primary TDO the same way. No register sits in any of these paths. Three address codes at the top of the code space are reserved. One unlinks every board, one links every board without an echo, and one leaves every board as it is. Any other address that does not belong to this board unlinks it. A `bypass` input forces the link without any frame, and `connected` reports the link whichever way it was made.

Top module: `scan_port_switch`

## Requirements
- R1: The internal controller copy goes to Test-Logic-Reset when `p_trst_n` is low, or after five consecutive rising `p_tck` edges with `p_tms` high, from any state.
- R2: A frame is a 0 start bit on `p_tdi` followed by AW address bits, least significant first, each sampled on a rising `p_tck` edge. When the frame matches `board_addr`, `connected` rises at the falling edge that follows the last address bit.
- R3: A frame counts only while the controller copy stays in Test-Logic-Reset (`p_tms`=1), Run-Test/Idle, Pause-DR or Pause-IR (`p_tms`=0). A frame sent in any other state is ignored. A state change in the middle of a frame discards the partial frame.
- R4: After a matching frame, `p_tdo_oe` is high and `p_tdo` carries the received address for AW falling edges, bit 0 first, each bit changed on falling `p_tck`. After any other frame, no echo is sent.
- R5: While linked, `s_tck`=`p_tck`, `s_tms`=`p_tms`, `s_tdi`=`p_tdi` and `p_tdo`=`s_tdo` through combinational paths, with `p_tdo_oe` high.
- R6: While unlinked and not echoing, `s_tck` is 0, `s_tms` is 1, `s_tdi` is 1 and `p_tdo_oe` is 0.
- R7: `bypass`=1 links the ports at once, with no frame.
- R8: `connected` is high exactly when the ports are linked, by address or by bypass.
- R9: The all-ones code unlinks. All-ones minus 1 links without an echo. All-ones minus 2 leaves the link unchanged.
- R10: A frame carrying any other address that is not `board_addr` unlinks a linked board.
- R11: `s_trst_n` always equals `p_trst_n`. A low `p_trst_n` unlinks at once and ends any echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_tck | input | 1 | Primary test clock |
| p_tms | input | 1 | Primary mode select |
| p_tdi | input | 1 | Primary data in, also carries address frames |
| p_trst_n | input | 1 | Primary test reset, active low, asynchronous |
| p_tdo | output | 1 | Primary data out: echo or secondary TDO |
| p_tdo_oe | output | 1 | Drive enable for `p_tdo` (low means high impedance) |
| s_tck | output | 1 | Secondary test clock |
| s_tms | output | 1 | Secondary mode select |
| s_tdi | output | 1 | Secondary data in |
| s_trst_n | output | 1 | Secondary test reset, active low |
| s_tdo | input | 1 | Secondary data out |
| board_addr | input | AW | Static address of this board |
| bypass | input | 1 | Force link without addressing |
| connected | output | 1 | Ports are linked |

## Verification
The assertions take for granted that `p_tdi` idles high whenever the controller rests in a stable state between frames, because a low level there is taken as a start bit. They also take for granted that `board_addr` does not change while a frame is in flight. The stimulus raises `p_tdi` at the end of every frame and during every state walk. It changes `board_addr` only after a reset walk with no frame open. All inputs change between clock edges, so a flop never samples an input on the same edge that it changes.

// File: rtl/scan_sw_pkg.sv
package scan_sw_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'd0,
    TS_IDLE     = 4'd1,
    TS_SEL_DR   = 4'd2,
    TS_CAP_DR   = 4'd3,
    TS_SHIFT_DR = 4'd4,
    TS_EX1_DR   = 4'd5,
    TS_PAUSE_DR = 4'd6,
    TS_EX2_DR   = 4'd7,
    TS_UPD_DR   = 4'd8,
    TS_SEL_IR   = 4'd9,
    TS_CAP_IR   = 4'd10,
    TS_SHIFT_IR = 4'd11,
    TS_EX1_IR   = 4'd12,
    TS_PAUSE_IR = 4'd13,
    TS_EX2_IR   = 4'd14,
    TS_UPD_IR   = 4'd15
  } tap_st_e;

  typedef enum logic [2:0] {
    ACT_DROP,
    ACT_ALL,
    ACT_KEEP,
    ACT_MINE,
    ACT_OTHER
  } link_act_e;

  function automatic tap_st_e tap_step(tap_st_e s, logic tms);
    tap_st_e n;
    case (s)
      TS_RESET:    n = tms ? TS_RESET   : TS_IDLE;
      TS_IDLE:     n = tms ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_DR:   n = tms ? TS_SEL_IR  : TS_CAP_DR;
      TS_CAP_DR:   n = tms ? TS_EX1_DR  : TS_SHIFT_DR;
      TS_SHIFT_DR: n = tms ? TS_EX1_DR  : TS_SHIFT_DR;
      TS_EX1_DR:   n = tms ? TS_UPD_DR  : TS_PAUSE_DR;
      TS_PAUSE_DR: n = tms ? TS_EX2_DR  : TS_PAUSE_DR;
      TS_EX2_DR:   n = tms ? TS_UPD_DR  : TS_SHIFT_DR;
      TS_UPD_DR:   n = tms ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_IR:   n = tms ? TS_RESET   : TS_CAP_IR;
      TS_CAP_IR:   n = tms ? TS_EX1_IR  : TS_SHIFT_IR;
      TS_SHIFT_IR: n = tms ? TS_EX1_IR  : TS_SHIFT_IR;
      TS_EX1_IR:   n = tms ? TS_UPD_IR  : TS_PAUSE_IR;
      TS_PAUSE_IR: n = tms ? TS_EX2_IR  : TS_PAUSE_IR;
      TS_EX2_IR:   n = tms ? TS_UPD_IR  : TS_SHIFT_IR;
      default:     n = tms ? TS_SEL_DR  : TS_IDLE;
    endcase
    return n;
  endfunction

  // The four resting states in which an address frame may be received
  function automatic logic tap_is_quiet(tap_st_e s);
    return (s == TS_RESET) || (s == TS_IDLE) ||
           (s == TS_PAUSE_DR) || (s == TS_PAUSE_IR);
  endfunction

endpackage

// File: rtl/sw_tap_track.sv
module sw_tap_track
  import scan_sw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_e st_o,
  output logic    hold_o
);

  tap_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_RESET;
    else        st_q <= tap_step(st_q, tms);
  end

  assign st_o   = st_q;
  assign hold_o = tap_is_quiet(st_q) && (tap_step(st_q, tms) == st_q);

endmodule

// File: rtl/sw_frame_rx.sv
module sw_frame_rx #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          tdi,
  output logic          done_o,
  output logic [AW-1:0] addr_o
);

  localparam int CW = $clog2(AW);
  localparam logic [CW-1:0] LAST = CW'(AW - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [AW-2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (!hold) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      busy_q <= !tdi;
      cnt_q  <= '0;
    end else begin
      sh_q <= {tdi, sh_q[AW-2:1]};
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = busy_q && hold && (cnt_q == LAST);
  assign addr_o = {tdi, sh_q};

endmodule

// File: rtl/sw_ack_tx.sv
module sw_ack_tx #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr,
  output logic          tdo_o,
  output logic          oe_o
);

  localparam int LW = $clog2(AW + 1);

  logic [AW-1:0] sh_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= addr;
      left_q <= LW'(AW);
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdo_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      tdo_o <= sh_q[0];
      oe_o  <= (left_q != '0);
    end
  end

endmodule

// File: rtl/sw_link_ctl.sv
module sw_link_ctl
  import scan_sw_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] board_addr,
  output logic          link_r_o,
  output logic          link_o,
  output logic          match_o
);

  localparam logic [AW-1:0] CODE_DROP = {AW{1'b1}};
  localparam logic [AW-1:0] CODE_ALL  = CODE_DROP - 1'b1;
  localparam logic [AW-1:0] CODE_NOP  = CODE_DROP - 2'd2;

  function automatic link_act_e classify(logic [AW-1:0] a, logic [AW-1:0] mine);
    if (a == CODE_DROP)     return ACT_DROP;
    else if (a == CODE_ALL) return ACT_ALL;
    else if (a == CODE_NOP) return ACT_KEEP;
    else if (a == mine)     return ACT_MINE;
    else                    return ACT_OTHER;
  endfunction

  link_act_e act;
  logic      link_q, link_n_q;

  assign act = classify(addr, board_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else if (done) begin
      case (act)
        ACT_ALL, ACT_MINE: link_q <= 1'b1;
        ACT_KEEP:          link_q <= link_q;
        default:           link_q <= 1'b0;
      endcase
    end
  end

  // Applied on the falling edge so that s_tck never switches while high
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) link_n_q <= 1'b0;
    else        link_n_q <= link_q;
  end

  assign link_r_o = link_q;
  assign link_o   = link_n_q;
  assign match_o  = done && (act == ACT_MINE);

endmodule

// File: rtl/scan_port_switch.sv
module scan_port_switch
  import scan_sw_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          p_tck,
  input  logic          p_tms,
  input  logic          p_tdi,
  input  logic          p_trst_n,
  output logic          p_tdo,
  output logic          p_tdo_oe,
  output logic          s_tck,
  output logic          s_tms,
  output logic          s_tdi,
  output logic          s_trst_n,
  input  logic          s_tdo,
  input  logic [AW-1:0] board_addr,
  input  logic          bypass,
  output logic          connected
);

  tap_st_e       tap_st;
  logic          quiet_hold;
  logic          frame_done;
  logic [AW-1:0] frame_addr;
  logic          link_r, link_n, addr_match;
  logic          ack_bit, ack_oe;

  sw_tap_track u_tap (
    .clk   (p_tck),
    .rst_n (p_trst_n),
    .tms   (p_tms),
    .st_o  (tap_st),
    .hold_o(quiet_hold)
  );

  sw_frame_rx #(.AW(AW)) u_rx (
    .clk   (p_tck),
    .rst_n (p_trst_n),
    .hold  (quiet_hold),
    .tdi   (p_tdi),
    .done_o(frame_done),
    .addr_o(frame_addr)
  );

  sw_link_ctl #(.AW(AW)) u_link (
    .clk       (p_tck),
    .rst_n     (p_trst_n),
    .done      (frame_done),
    .addr      (frame_addr),
    .board_addr(board_addr),
    .link_r_o  (link_r),
    .link_o    (link_n),
    .match_o   (addr_match)
  );

  sw_ack_tx #(.AW(AW)) u_ack (
    .clk  (p_tck),
    .rst_n(p_trst_n),
    .load (addr_match),
    .addr (frame_addr),
    .tdo_o(ack_bit),
    .oe_o (ack_oe)
  );

  assign connected = link_n | bypass;
  assign s_tck     = connected & p_tck;
  assign s_tms     = connected ? p_tms : 1'b1;
  assign s_tdi     = connected ? p_tdi : 1'b1;
  assign s_trst_n  = p_trst_n;
  assign p_tdo     = ack_oe ? ack_bit : (connected ? s_tdo : 1'b0);
  assign p_tdo_oe  = ack_oe | connected;

endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import scan_sw_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          p_tck,
  input logic          p_trst_n,
  input logic          p_tms,
  input logic          p_tdi,
  input logic          s_tck,
  input logic          s_tms,
  input logic          s_tdi,
  input logic          s_trst_n,
  input logic          bypass,
  input logic          connected,
  input tap_st_e       tap_st,
  input logic          frame_done,
  input logic [AW-1:0] frame_addr,
  input logic [AW-1:0] board_addr,
  input logic          link_r
);

  localparam logic [AW-1:0] CODE_NOP = {AW{1'b1}} - 2'd2;

  logic [2:0] ones_run;

  always_ff @(posedge p_tck or negedge p_trst_n) begin
    if (!p_trst_n)               ones_run <= '0;
    else if (!p_tms)             ones_run <= '0;
    else if (ones_run != 3'd5)   ones_run <= ones_run + 1'b1;
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge p_tck) disable iff (!p_trst_n)
    (ones_run == 3'd5) |-> (tap_st == TS_RESET));

  // R3
  frame_in_quiet_chk: assert property (@(posedge p_tck) disable iff (!p_trst_n)
    frame_done |-> tap_is_quiet(tap_st));

  // R10
  foreign_addr_drop_chk: assert property (@(posedge p_tck) disable iff (!p_trst_n)
    (frame_done && frame_addr != board_addr && frame_addr < CODE_NOP) |=> !link_r);

  // R7
  bypass_link_chk: assert property (@(posedge p_tck) disable iff (!p_trst_n)
    bypass |-> connected);

  // R6
  idle_secondary_chk: assert property (@(posedge p_tck) disable iff (!p_trst_n)
    !connected |-> (!s_tck && s_tms && s_tdi));

  // R5
  passthrough_chk: assert property (@(posedge p_tck) disable iff (!p_trst_n)
    connected |-> (s_tck == p_tck && s_tms == p_tms && s_tdi == p_tdi));

  // R11
  trst_follow_chk: assert property (@(negedge p_tck) disable iff (!p_trst_n)
    s_trst_n == p_trst_n);

endmodule

bind scan_port_switch sw_checker #(.AW(AW)) u_chk (
  .p_tck     (p_tck),
  .p_trst_n  (p_trst_n),
  .p_tms     (p_tms),
  .p_tdi     (p_tdi),
  .s_tck     (s_tck),
  .s_tms     (s_tms),
  .s_tdi     (s_tdi),
  .s_trst_n  (s_trst_n),
  .bypass    (bypass),
  .connected (connected),
  .tap_st    (tap_st),
  .frame_done(frame_done),
  .frame_addr(frame_addr),
  .board_addr(board_addr),
  .link_r    (link_r)
);

// File: tb/sim_scan_port_switch.sv
module sim_scan_port_switch;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW    = 4;
  localparam int NCODE = 1 << AW;
  localparam int NUSER = NCODE - 3;
  localparam logic [AW-1:0] C_DROP = NCODE - 1;
  localparam logic [AW-1:0] C_ALL  = NCODE - 2;
  localparam logic [AW-1:0] C_NOP  = NCODE - 3;

  logic p_tck = 1'b0, p_tms, p_tdi, p_trst_n, s_tdo, bypass;
  logic p_tdo, p_tdo_oe, s_tck, s_tms, s_tdi, s_trst_n, connected;
  logic [AW-1:0] board_addr;
  int nchk = 0, nfail = 0;
  bit exp_link;

  always #2 p_tck = ~p_tck;

  scan_port_switch #(.AW(AW)) u0 (
    .p_tck(p_tck), .p_tms(p_tms), .p_tdi(p_tdi), .p_trst_n(p_trst_n),
    .p_tdo(p_tdo), .p_tdo_oe(p_tdo_oe), .s_tck(s_tck), .s_tms(s_tms),
    .s_tdi(s_tdi), .s_trst_n(s_trst_n), .s_tdo(s_tdo),
    .board_addr(board_addr), .bypass(bypass), .connected(connected)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  task automatic pulse(input logic tms, input logic tdi);
    p_tms = tms; p_tdi = tdi;
    @(posedge p_tck); #1;
  endtask

  task automatic go_reset();
    repeat (5) pulse(1'b1, 1'b1);
  endtask

  // 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Pause-DR, 3 Pause-IR
  task automatic go_state(input int k);
    go_reset();
    if (k >= 1) pulse(1'b0, 1'b1);
    if (k == 2) begin pulse(1,1); pulse(0,1); pulse(1,1); pulse(0,1); end
    if (k == 3) begin pulse(1,1); pulse(1,1); pulse(0,1); pulse(1,1); pulse(0,1); end
  endtask

  task automatic send_frame(input logic hold, input logic [AW-1:0] code);
    pulse(hold, 1'b0);
    for (int i = 0; i < AW; i++) pulse(hold, code[i]);
    p_tdi = 1'b1;
  endtask

  // Observe the AW+1 falling edges after a frame
  task automatic check_window(input logic [AW-1:0] code, input bit ack, input bit lnk);
    for (int i = 0; i <= AW; i++) begin
      @(negedge p_tck); #0.5;
      if (i == 0) check("R2 R8 R9 R10 connected", connected, lnk);
      check("R4 p_tdo_oe", p_tdo_oe, (ack && i < AW) || lnk);
      if (ack && i < AW) check("R4 echo bit", p_tdo, code[i]);
      else if (lnk)      check("R5 p_tdo from s_tdo", p_tdo, s_tdo);
    end
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    p_trst_n = 1'b0; p_tms = 1'b1; p_tdi = 1'b1; s_tdo = 1'b1;
    bypass = 1'b0; board_addr = '0;
    repeat (3) @(posedge p_tck); #1;
    // reset state: R11 R6
    check("R11 s_trst_n in reset", s_trst_n, 0);
    check("R11 connected in reset", connected, 0);
    check("R6 s_tck held low", s_tck, 0);
    check("R6 s_tms held high", s_tms, 1);
    check("R6 p_tdo_oe off", p_tdo_oe, 0);
    p_trst_n = 1'b1;
    #0.5 check("R11 s_trst_n follows", s_trst_n, 1);

    // sweep every board address against every frame code
    for (int b = 0; b < NUSER; b++) begin
      board_addr = AW'(b);
      go_reset();
      send_frame(1'b1, C_DROP);
      check_window(C_DROP, 0, 0);
      exp_link = 0;
      for (int c = 0; c < NCODE; c++) begin
        bit ack;
        int k;
        k = (b + c) % 4;
        go_state(k);
        ack = (c == b);
        if (c == C_DROP)     exp_link = 0;
        else if (c == C_ALL) exp_link = 1;
        else if (c == C_NOP) exp_link = exp_link;
        else                 exp_link = (c == b);
        send_frame(k == 0, AW'(c));
        check_window(AW'(c), ack, exp_link);
      end
    end

    board_addr = AW'(5);
    s_tdo = 1'b0;

    // R3: frame in Shift-DR is ignored
    go_state(1);
    send_frame(0, C_DROP);
    check_window(C_DROP, 0, 0);
    pulse(1,1); pulse(0,1); pulse(0,1);
    send_frame(0, AW'(5));
    pulse(1,1); pulse(1,1); pulse(0,1);
    @(negedge p_tck); #0.5;
    check("R3 shift-dr frame ignored", connected, 0);

    // R1: five TMS-high clocks from Shift-DR reach Test-Logic-Reset
    go_state(1);
    pulse(1,1); pulse(0,1); pulse(0,1);
    go_reset();
    send_frame(1, AW'(5));
    check_window(AW'(5), 1, 1);
    check("R1 frame accepted after five ones", connected, 1);

    // R3: aborted drop frame leaves link intact
    go_state(1);
    pulse(0, 0);
    for (int i = 0; i < AW - 1; i++) pulse(0, 1);
    pulse(1,1); pulse(1,1); pulse(1,1);
    go_state(1);
    repeat (3) pulse(0, 1);
    @(negedge p_tck); #0.5;
    check("R3 aborted frame no effect", connected, 1);

    // R5: combinational passthrough while linked
    @(posedge p_tck); #1;
    check("R5 s_tck high", s_tck, 1);
    for (int v = 0; v < 4; v++) begin
      p_tdi = v[0]; s_tdo = v[1];
      #0.2;
      check("R5 s_tdi", s_tdi, v[0]);
      check("R5 p_tdo", p_tdo, v[1]);
    end
    p_tms = 1'b1; #0.2 check("R5 s_tms", s_tms, 1);
    p_tms = 1'b0; p_tdi = 1'b1; #0.2 check("R5 s_tms low", s_tms, 0);
    @(negedge p_tck); #0.5 check("R5 s_tck low", s_tck, 0);

    // R9: no-op keeps link, drop clears it
    send_frame(0, C_NOP);
    check_window(C_NOP, 0, 1);
    send_frame(0, C_DROP);
    check_window(C_DROP, 0, 0);

    // R6: unlinked secondary held
    @(posedge p_tck); #1;
    p_tdi = 1'b0; p_tms = 1'b1; #0.2;
    check("R6 s_tdi held", s_tdi, 1);
    check("R6 s_tck held", s_tck, 0);
    p_tms = 1'b0; #0.2 check("R6 s_tms held", s_tms, 1);
    p_tdi = 1'b1;

    // R7 R8: bypass
    bypass = 1'b1; s_tdo = 1'b1; #0.2;
    check("R7 bypass links", connected, 1);
    check("R8 oe under bypass", p_tdo_oe, 1);
    check("R7 p_tdo via bypass", p_tdo, 1);
    check("R7 s_tck via bypass", s_tck, p_tck);
    bypass = 1'b0; #0.2;
    check("R8 bypass released", connected, 0);

    // R10: foreign address unlinks
    send_frame(0, AW'(5));
    check_window(AW'(5), 1, 1);
    send_frame(0, AW'(6));
    check_window(AW'(6), 0, 0);

    // R11: trst unlinks at once
    send_frame(0, AW'(5));
    @(negedge p_tck); #0.5;
    p_trst_n = 1'b0; #0.2;
    check("R11 trst unlinks", connected, 0);
    check("R11 trst ends echo", p_tdo_oe, 0);
    check("R11 s_trst_n low", s_trst_n, 0);
    @(posedge p_tck); #1;
    p_trst_n = 1'b1;

    finish_run();
  end

endmodule